// File: doc/BRIEF.md
# Per-Line Modem Status and Dataset-Change Controller

This block keeps the modem-control half of a receive status word for a bank of serial lines. Each line has read-only ring, clear-to-send, carrier and dataset-change flags, and software-writable data-terminal-ready, request-to-send, secondary-transmit and dataset-interrupt-enable bits. A receive interrupt-enable bit is also held. The flags move in response to three things: connect and disconnect pulses from the line side, and software writes that change data-terminal-ready.

When a flag changes while dataset interrupts are enabled, the line raises a dataset interrupt request. Dropping data-terminal-ready on a connected line produces a one-cycle hangup request toward the line side. A status read returns the word one cycle later and consumes the dataset-change flag and its request. A per-line strap selects modem mode. With the strap off the line behaves as a plain receiver: only the interrupt-enable bit is writable and every modem bit reads as zero.

Top module: `mdm_dsc_ctrl`

## Requirements
- R1: After reset every status word reads 0x0000, and every interrupt request, the combined interrupt and every hangup output are 0.
- R2: Status bit positions: 15 dataset change, 14 ring, 13 clear-to-send, 12 carrier, 6 interrupt enable, 5 dataset interrupt enable, 3 secondary transmit, 2 request-to-send, 1 data-terminal-ready. All other bits read 0. In modem mode a write stores bits 6, 5, 3, 2 and 1 only.
- R3: A connect pulse on a modem line sets carrier, clear-to-send and dataset change if data-terminal-ready is 1. Otherwise it sets ring and dataset change.
- R4: A write that raises data-terminal-ready on a connected modem line clears ring and sets carrier, clear-to-send and dataset change.
- R5: A write that changes data-terminal-ready without raising it on a connected line clears carrier, ring and clear-to-send. If that write lowers it on a connected line, it also pulses that line's hangup output for exactly one cycle, sets dataset change if carrier was 1, and marks the line disconnected.
- R6: A disconnect pulse on a modem line sets dataset change if carrier was 1, then clears carrier, ring and clear-to-send. With carrier 0 it changes no visible bit.
- R7: Any setting of dataset change raises the line's request when dataset interrupt enable is 1. A write with bit 5 = 0 clears the request. A write with bit 5 = 1 while enable was 0 and dataset change is pending raises it. The combined interrupt output is the OR of all line requests.
- R8: A status read returns the word as it was at the read edge, valid the following cycle. It clears dataset change and the request of that line. A setting in the same cycle wins over the clear.
- R9: A clear pulse resets all lines: modem lines keep data-terminal-ready, and every other status bit and every request go to 0. The clear overrides a write or line event in the same cycle.
- R10: When a write and a connect or disconnect pulse hit the same line in the same cycle, the write is applied and the line event is discarded.
- R11: On a line with the strap off, a write stores only bit 6, line events change no visible bit, no request is raised, and the modem bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_mode_i | input | NLINES | Per-line strap, 1 = modem mode |
| wr_en_i | input | 1 | Status write strobe |
| wr_line_i | input | LW | Line addressed by the write |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Status read strobe |
| rd_line_i | input | LW | Line addressed by the read |
| rd_data_o | output | 16 | Read data, valid the cycle after the strobe |
| conn_i | input | NLINES | Per-line connect pulse |
| disc_i | input | NLINES | Per-line disconnect pulse |
| clr_i | input | 1 | Clear pulse for all lines |
| dsi_req_o | output | NLINES | Per-line dataset interrupt request |
| dsi_irq_o | output | 1 | OR of all dataset interrupt requests |
| hangup_o | output | NLINES | Per-line one-cycle hangup request |

## Verification
The bench targets the order-sensitive cases. One is a raise of data-terminal-ready on a line that is not connected: a design that treated it like a connected raise would report a phantom carrier. Another is a drop while carrier is present: getting the order wrong loses the dataset-change flag or skips the hangup. It also checks that enabling dataset interrupts with a change already pending raises the request, which a design that only reacts to events would miss. Further cases are a write and a disconnect colliding on one line, where a design that merges them clears carrier early, and a clear that keeps data-terminal-ready on modem lines only. Finally it toggles the strap so that stale modem bits must be masked.

// File: rtl/mdm_dsc_pkg.sv
// Package: shared bit positions and record types for the modem status block.
// Assumes a 16-bit status word; positions are fixed by the software view.
package mdm_dsc_pkg;

    localparam int STAT_W   = 16;
    localparam int B_DSC    = 15;
    localparam int B_RING   = 14;
    localparam int B_CTS    = 13;
    localparam int B_CD     = 12;
    localparam int B_IE     = 6;
    localparam int B_DSIE   = 5;
    localparam int B_STX    = 3;
    localparam int B_RTS    = 2;
    localparam int B_DTR    = 1;

    // Full per-line status record.
    typedef struct packed {
        logic dsc;
        logic ring;
        logic cts;
        logic cd;
        logic ie;
        logic dsie;
        logic stx;
        logic rts;
        logic dtr;
    } mdm_stat_t;

    // Software-writable fields extracted from a write.
    typedef struct packed {
        logic ie;
        logic dsie;
        logic stx;
        logic rts;
        logic dtr;
    } mdm_wr_t;

    // Build the visible word; modem bits are masked when the strap is off.
    function automatic logic [STAT_W-1:0] pack_status(mdm_stat_t s, logic modem);
        logic [STAT_W-1:0] w;
        w          = '0;
        w[B_IE]    = s.ie;
        if (modem) begin
            w[B_DSC]  = s.dsc;
            w[B_RING] = s.ring;
            w[B_CTS]  = s.cts;
            w[B_CD]   = s.cd;
            w[B_DSIE] = s.dsie;
            w[B_STX]  = s.stx;
            w[B_RTS]  = s.rts;
            w[B_DTR]  = s.dtr;
        end
        return w;
    endfunction

    // Extract the writable fields from a raw write word.
    function automatic mdm_wr_t unpack_write(logic [STAT_W-1:0] d);
        mdm_wr_t f;
        f.ie   = d[B_IE];
        f.dsie = d[B_DSIE];
        f.stx  = d[B_STX];
        f.rts  = d[B_RTS];
        f.dtr  = d[B_DTR];
        return f;
    endfunction

endpackage

// File: rtl/mdm_line.sv
// Module: one line's modem status state, dataset-change request and hangup.
// Assumes at most one of write/connect/disconnect acts per cycle: a clear
// overrides all, a write overrides line events, connect overrides disconnect.
// A read in the same cycle is applied first so any later setting wins.
module mdm_line
    import mdm_dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              wr_i,
    input  mdm_wr_t           wr_f_i,
    input  logic              rd_i,
    input  logic              conn_i,
    input  logic              disc_i,
    input  logic              clr_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              req_o,
    output logic              hup_o
);

    mdm_stat_t st_q, st_d;
    logic      conn_q, conn_d;
    logic      req_q, req_d;
    logic      hup_q, hup_d;

    // Next-state decision for status, connection, request and hangup.
    always_comb begin
        st_d   = st_q;
        conn_d = conn_q;
        req_d  = req_q;
        hup_d  = 1'b0;

        if (rd_i) begin
            st_d.dsc = 1'b0;
            req_d    = 1'b0;
        end

        if (clr_i) begin
            st_d  = '0;
            if (strap_i) begin
                st_d.dtr = st_q.dtr;
            end
            req_d = 1'b0;
        end else if (wr_i) begin
            if (!strap_i) begin
                st_d.ie = wr_f_i.ie;
            end else begin
                if (!wr_f_i.dsie) begin
                    req_d = 1'b0;
                end else if (st_d.dsc && !st_q.dsie) begin
                    req_d = 1'b1;
                end
                if (wr_f_i.dtr != st_q.dtr) begin
                    if (wr_f_i.dtr && conn_q) begin
                        st_d.ring = 1'b0;
                        st_d.cd   = 1'b1;
                        st_d.cts  = 1'b1;
                        st_d.dsc  = 1'b1;
                        if (wr_f_i.dsie) begin
                            req_d = 1'b1;
                        end
                    end else begin
                        if (conn_q) begin
                            hup_d  = 1'b1;
                            conn_d = 1'b0;
                            if (st_q.cd) begin
                                st_d.dsc = 1'b1;
                                if (wr_f_i.dsie) begin
                                    req_d = 1'b1;
                                end
                            end
                        end
                        st_d.cd   = 1'b0;
                        st_d.ring = 1'b0;
                        st_d.cts  = 1'b0;
                    end
                end
                st_d.ie   = wr_f_i.ie;
                st_d.dsie = wr_f_i.dsie;
                st_d.stx  = wr_f_i.stx;
                st_d.rts  = wr_f_i.rts;
                st_d.dtr  = wr_f_i.dtr;
            end
        end else if (conn_i) begin
            conn_d = 1'b1;
            if (strap_i) begin
                if (st_q.dtr) begin
                    st_d.cd  = 1'b1;
                    st_d.cts = 1'b1;
                end else begin
                    st_d.ring = 1'b1;
                end
                st_d.dsc = 1'b1;
                if (st_q.dsie) begin
                    req_d = 1'b1;
                end
            end
        end else if (disc_i) begin
            conn_d = 1'b0;
            if (strap_i) begin
                if (st_q.cd) begin
                    st_d.dsc = 1'b1;
                    if (st_q.dsie) begin
                        req_d = 1'b1;
                    end
                end
                st_d.cd   = 1'b0;
                st_d.ring = 1'b0;
                st_d.cts  = 1'b0;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            conn_q <= 1'b0;
            req_q  <= 1'b0;
            hup_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            conn_q <= conn_d;
            req_q  <= req_d;
            hup_q  <= hup_d;
        end
    end

    // Visible word and registered outputs.
    always_comb begin
        stat_o = pack_status(st_q, strap_i);
        req_o  = req_q;
        hup_o  = hup_q;
    end

endmodule

// File: rtl/mdm_rd_port.sv
// Module: registered read port; selects one line's word at the read edge.
// Assumes rd_line_i addresses an existing line.
module mdm_rd_port
    import mdm_dsc_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en_i,
    input  logic [LW-1:0]                  rd_line_i,
    input  logic [NLINES-1:0][STAT_W-1:0]  stat_i,
    output logic [STAT_W-1:0]              rd_data_o
);

    logic [STAT_W-1:0] sel_word;

    // Pick the addressed line's word.
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NLINES; k++) begin
            if (rd_line_i == LW'(k)) begin
                sel_word = stat_i[k];
            end
        end
    end

    // Capture the word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= sel_word;
        end
    end

endmodule

// File: rtl/mdm_dsc_ctrl.sv
// Module: top of the modem status block; decodes accesses to one of NLINES
// line slices, collects requests and drives the read port.
// Assumes one write and one read per cycle, each addressing a single line.
module mdm_dsc_ctrl
    import mdm_dsc_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLINES-1:0]  line_mode_i,
    input  logic               wr_en_i,
    input  logic [LW-1:0]      wr_line_i,
    input  logic [STAT_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    input  logic [LW-1:0]      rd_line_i,
    output logic [STAT_W-1:0]  rd_data_o,
    input  logic [NLINES-1:0]  conn_i,
    input  logic [NLINES-1:0]  disc_i,
    input  logic               clr_i,
    output logic [NLINES-1:0]  dsi_req_o,
    output logic               dsi_irq_o,
    output logic [NLINES-1:0]  hangup_o
);

    mdm_wr_t                       wr_f;
    logic [NLINES-1:0]             wr_sel;
    logic [NLINES-1:0]             rd_sel;
    logic [NLINES-1:0][STAT_W-1:0] stat_w;
    logic                          unused_wr_bits;

    // Extract writable fields; remaining bits are intentionally dropped.
    always_comb begin
        wr_f           = unpack_write(wr_data_i);
        unused_wr_bits = ^{wr_data_i[15:7], wr_data_i[4], wr_data_i[0]};
    end

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            // Per-line access decode.
            always_comb begin
                wr_sel[i] = wr_en_i && (wr_line_i == LW'(i));
                rd_sel[i] = rd_en_i && (rd_line_i == LW'(i));
            end

            mdm_line u_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .strap_i (line_mode_i[i]),
                .wr_i    (wr_sel[i]),
                .wr_f_i  (wr_f),
                .rd_i    (rd_sel[i]),
                .conn_i  (conn_i[i]),
                .disc_i  (disc_i[i]),
                .clr_i   (clr_i),
                .stat_o  (stat_w[i]),
                .req_o   (dsi_req_o[i]),
                .hup_o   (hangup_o[i])
            );
        end
    endgenerate

    // Combined dataset interrupt.
    always_comb begin
        dsi_irq_o = |dsi_req_o;
    end

    mdm_rd_port #(
        .NLINES (NLINES),
        .LW     (LW)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_line_i (rd_line_i),
        .stat_i    (stat_w),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/mdm_dsc_chk.sv
// Module: property checker for mdm_dsc_ctrl, attached by bind below.
// Assumes the same parameters as the instance it is bound to.
module mdm_dsc_chk #(
    parameter int NLINES = 4,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] line_mode_i,
    input logic              wr_en_i,
    input logic [LW-1:0]     wr_line_i,
    input logic              wr_dsie_i,
    input logic              rd_en_i,
    input logic [LW-1:0]     rd_line_i,
    input logic [NLINES-1:0] conn_i,
    input logic [NLINES-1:0] disc_i,
    input logic              clr_i,
    input logic [NLINES-1:0] dsi_req_o,
    input logic [NLINES-1:0] hangup_o
);

    // Only one line can be written per cycle, so one hangup at most.
    a_r5_hangup_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hangup_o));

    // The clear pulse leaves no request standing.
    a_r9_clear_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (dsi_req_o == '0));

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_chk
            // A hangup follows a modem-mode write to that line.
            a_r5_hangup_after_write: assert property (@(posedge clk) disable iff (!rst_n)
                hangup_o[i] |-> $past(wr_en_i && (wr_line_i == LW'(i)) && line_mode_i[i]));

            // Writing the dataset enable as 0 drops the request.
            a_r7_dsie0_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en_i && (wr_line_i == LW'(i)) && line_mode_i[i] && !wr_dsie_i)
                |=> !dsi_req_o[i]);

            // A read with nothing else on the line leaves no request.
            a_r8_read_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en_i && (rd_line_i == LW'(i)) && !(wr_en_i && (wr_line_i == LW'(i)))
                 && !conn_i[i] && !disc_i[i]) |=> !dsi_req_o[i]);

            // Requests only rise on a strapped line.
            a_r11_req_needs_strap: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(dsi_req_o[i]) |-> $past(line_mode_i[i]));
        end
    endgenerate

endmodule

bind mdm_dsc_ctrl mdm_dsc_chk #(
    .NLINES (NLINES),
    .LW     (LW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_mode_i (line_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_line_i   (wr_line_i),
    .wr_dsie_i   (wr_data_i[5]),
    .rd_en_i     (rd_en_i),
    .rd_line_i   (rd_line_i),
    .conn_i      (conn_i),
    .disc_i      (disc_i),
    .clr_i       (clr_i),
    .dsi_req_o   (dsi_req_o),
    .hangup_o    (hangup_o)
);

// File: tb/sim_mdm_dsc_ctrl.sv
// Bench for mdm_dsc_ctrl: vector table walk, then directed cases.
module sim_mdm_dsc_ctrl;

    localparam int NL = 4;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] mode;
    logic          wr_en;
    logic [LW-1:0] wr_line;
    logic [15:0]   wr_data;
    logic          rd_en;
    logic [LW-1:0] rd_line;
    logic [15:0]   rd_data;
    logic [NL-1:0] conn;
    logic [NL-1:0] disc;
    logic          clr;
    logic [NL-1:0] req;
    logic          irq;
    logic [NL-1:0] hup;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mdm_dsc_ctrl #(.NLINES(NL), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_mode_i(mode),
        .wr_en_i(wr_en), .wr_line_i(wr_line), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_line_i(rd_line), .rd_data_o(rd_data),
        .conn_i(conn), .disc_i(disc), .clr_i(clr),
        .dsi_req_o(req), .dsi_irq_o(irq), .hangup_o(hup)
    );

    // kind: 0 write, 1 connect, 2 disconnect
    // {kind, line, data, expected word, expected request, expected hangup}
    localparam logic [37:0] VEC [14] = '{
        {2'd0, 2'd0, 16'h0020, 16'h0020, 1'b0, 1'b0},
        {2'd1, 2'd0, 16'h0000, 16'hC020, 1'b1, 1'b0},
        {2'd0, 2'd0, 16'h0022, 16'hB022, 1'b1, 1'b0},
        {2'd0, 2'd0, 16'h002E, 16'h302E, 1'b0, 1'b0},
        {2'd0, 2'd0, 16'h000C, 16'h800C, 1'b0, 1'b1},
        {2'd0, 2'd0, 16'h0020, 16'h0020, 1'b0, 1'b0},
        {2'd0, 2'd1, 16'h0022, 16'h0022, 1'b0, 1'b0},
        {2'd1, 2'd1, 16'h0000, 16'hB022, 1'b1, 1'b0},
        {2'd2, 2'd1, 16'h0000, 16'h8022, 1'b1, 1'b0},
        {2'd2, 2'd1, 16'h0000, 16'h0022, 1'b0, 1'b0},
        {2'd0, 2'd2, 16'hFFFF, 16'h0040, 1'b0, 1'b0},
        {2'd1, 2'd2, 16'h0000, 16'h0040, 1'b0, 1'b0},
        {2'd0, 2'd2, 16'h0000, 16'h0000, 1'b0, 1'b0},
        {2'd1, 2'd0, 16'h0000, 16'hC020, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_write(input int ln, input logic [15:0] d);
        wr_en = 1'b1; wr_line = LW'(ln); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_conn(input int ln);
        conn[ln] = 1'b1;
        tick();
        conn = '0;
    endtask

    task automatic do_disc(input int ln);
        disc[ln] = 1'b1;
        tick();
        disc = '0;
    endtask

    task automatic do_read(input int ln, output logic [15:0] d);
        rd_en = 1'b1; rd_line = LW'(ln);
        tick();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        rst_n = 1'b0; mode = 4'b0011; wr_en = 1'b0; wr_line = '0; wr_data = '0;
        rd_en = 1'b0; rd_line = '0; conn = '0; disc = '0; clr = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state on every line
        chk("R1 req", {12'd0, req}, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        chk("R1 hangup", {12'd0, hup}, 16'h0);
        for (int l = 0; l < NL; l++) begin
            do_read(l, rv);
            chk("R1 word", rv, 16'h0000);
        end

        // R2 R3 R4 R5 R6 R7 R8 R11: table walk
        for (int v = 0; v < 14; v++) begin
            logic [1:0]  kind;
            int          ln;
            logic [15:0] d, ew;
            logic        er, eh;
            {kind, ln[1:0], d, ew, er, eh} = VEC[v];
            ln = ln & 3;
            case (kind)
                2'd0:    do_write(ln, d);
                2'd1:    do_conn(ln);
                default: do_disc(ln);
            endcase
            chk($sformatf("R5 hangup vec %0d", v), {15'd0, hup[ln]}, {15'd0, eh});
            chk($sformatf("R7 req vec %0d", v), {15'd0, req[ln]}, {15'd0, er});
            do_read(ln, rv);
            chk($sformatf("R2 word vec %0d", v), rv, ew);
        end
        chk("R8 req after read", {15'd0, req[0]}, 16'h0);

        // R7: enabling dataset interrupts with a pending change
        do_write(1, 16'h0002);
        do_conn(1);
        chk("R7 no req while disabled", {15'd0, req[1]}, 16'h0);
        do_write(1, 16'h0022);
        chk("R7 late enable raises req", {15'd0, req[1]}, 16'h1);
        chk("R7 combined irq", {15'd0, irq}, 16'h1);
        do_read(1, rv);
        chk("R3 word", rv, 16'hB022);
        chk("R8 read clears req", {15'd0, req[1]}, 16'h0);
        chk("R8 irq drops", {15'd0, irq}, 16'h0);

        // R10: write and disconnect in the same cycle on line 1
        wr_en = 1'b1; wr_line = 2'd1; wr_data = 16'h0022; disc[1] = 1'b1;
        tick();
        wr_en = 1'b0; disc = '0;
        chk("R10 no req", {15'd0, req[1]}, 16'h0);
        do_read(1, rv);
        chk("R10 event dropped", rv, 16'h3022);
        do_disc(1);
        chk("R6 req", {15'd0, req[1]}, 16'h1);
        do_read(1, rv);
        chk("R6 word", rv, 16'h8022);

        // R9: clear keeps DTR on modem lines only and drops requests
        do_write(1, 16'h002E);
        do_write(2, 16'h0040);
        do_write(0, 16'h0022);
        chk("R4 req before clear", {15'd0, req[0]}, 16'h1);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        chk("R9 requests", {12'd0, req}, 16'h0);
        do_read(0, rv);
        chk("R9 line0", rv, 16'h0002);
        do_read(1, rv);
        chk("R9 line1", rv, 16'h0002);
        do_read(2, rv);
        chk("R9 line2", rv, 16'h0000);

        // R5: DTR drop on connected line without carrier
        do_write(0, 16'h0060);
        chk("R5 hangup pulse", {12'd0, hup}, 16'h0001);
        tick();
        chk("R5 hangup one cycle", {12'd0, hup}, 16'h0000);
        do_read(0, rv);
        chk("R5 no change flag", rv, 16'h0060);

        // R11: strap off masks modem bits
        do_conn(0);
        chk("R3 ring req", {15'd0, req[0]}, 16'h1);
        mode[0] = 1'b0;
        do_read(0, rv);
        chk("R11 masked", rv, 16'h0040);
        mode[0] = 1'b1;
        do_read(0, rv);
        chk("R11 unmasked", rv, 16'h4060);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule